// File: doc/BRIEF.md
# Lane-Split 48-bit Add/Subtract Unit

This block adds or subtracts two 48-bit operands and can be cut, by a parameter, into one 48-bit lane, two 24-bit lanes or four 12-bit lanes that compute side by side with no carry passing between them. One operand is built by placing a 30-bit upper input directly above an 18-bit lower input. The other operand arrives whole on a 48-bit input. Each lane reports its own carry on a fixed position of a 4-bit carry vector.

A 4-bit operation code picks addition or subtraction. Any other code makes the block keep its previous outputs. A single external carry input enters the lowest lane only. Result and carry vector are registered, so they appear one clock after the inputs. A synchronous reset clears both.

Top module: `simd_add48`

## Requirements
- R1: The joined operand is {op_hi, op_lo}, with op_hi in the upper bits. With mode 4'b0000 (add), each lane's result is (op_c lane + joined lane + lane carry-in) modulo 2^lane_width, and the lane's carry is bit lane_width of that sum.
- R2: LANES may be 1, 2 or 4, and the lane width is (HI_W+LO_W)/LANES. No carry moves from one lane into the next.
- R3: carry_in is the carry-in of lane 0 only. In add mode, every other lane has a carry-in of 0.
- R4: With mode 4'b0011 (subtract), each lane computes op_c lane + ~joined lane + lane carry-in. Lane 0 uses carry_in, so carry_in=1 gives op_c minus joined. Every other lane uses a carry-in of 1. The lane carry is 1 when no borrow occurs.
- R5: With four lanes, carry_out[k] holds the carry of lane k, where lane 0 is the least significant.
- R6: With two lanes, carry_out[1] holds the lower lane's carry and carry_out[3] holds the upper lane's carry. Bits 0 and 2 are 0.
- R7: With one lane, carry_out[3] holds the lane carry and bits 2 to 0 are 0.
- R8: Any mode other than 4'b0000 or 4'b0011 leaves result and carry_out unchanged on that clock edge.
- R9: result and carry_out change only at a rising clock edge, one cycle after the inputs are presented. A high rst at a rising edge sets both to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_hi | input | HI_W (30) | Upper part of the joined operand |
| op_lo | input | LO_W (18) | Lower part of the joined operand |
| op_c | input | HI_W+LO_W (48) | Second operand |
| mode | input | 4 | Operation code: 0000 add, 0011 subtract, any other value holds |
| carry_in | input | 1 | Carry into lane 0 |
| result | output | HI_W+LO_W (48) | Registered lane results |
| carry_out | output | 4 | Registered lane carries at fixed positions |

## Verification
Three small copies of the block (8 bits wide, with one, two and four lanes) receive the same stimulus. The joined operand sweeps through every value, and the second operand walks a 16-step ladder that includes all-zeros and all-ones. Both operations are applied with both carry-in values. Because lanes are only 2 or 4 bits wide, nearly every carry, borrow and lane-edge wrap is reached, which separates a chain correctly cut at lane boundaries from one that leaks across them, and a correctly placed carry bit from a swapped one. On the full 48-bit instance, directed vectors confirm that carry_in reaches only lane 0, that all-ones operands wrap each lane on its own, that every non-operation code holds the output, and when the output changes relative to the clock and reset.

// File: rtl/simd_add_pkg.sv
`timescale 1ns/1ps
package simd_add_pkg;

   localparam int MODE_W = 4;
   localparam int CO_W   = 4;

   typedef enum logic [MODE_W-1:0] {
      OP_ADD = 4'b0000,
      OP_SUB = 4'b0011
   } op_e;

   // position of lane k's carry inside the 4-bit carry vector
   function automatic int carry_slot(input int lanes, input int k);
      if (lanes == 4)      return k;
      else if (lanes == 2) return 2 * k + 1;
      else                 return 3;
   endfunction

endpackage

// File: rtl/sadd_decode.sv
`timescale 1ns/1ps
module sadd_decode
   import simd_add_pkg::*;
#(
   parameter int HI_W = 30,
   parameter int LO_W = 18,
   localparam int DW  = HI_W + LO_W
) (
   input  logic [HI_W-1:0]   part_hi,
   input  logic [LO_W-1:0]   part_lo,
   input  logic [MODE_W-1:0] mode,
   output logic [DW-1:0]     opnd_eff,
   output logic              is_sub,
   output logic              is_valid
);

   logic [DW-1:0] joined;

   always_comb begin
      joined   = {part_hi, part_lo};
      is_sub   = (mode == OP_SUB);
      is_valid = (mode == OP_ADD) || (mode == OP_SUB);
      opnd_eff = is_sub ? ~joined : joined;
   end

endmodule

// File: rtl/sadd_lane.sv
`timescale 1ns/1ps
module sadd_lane #(
   parameter int W = 12
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         ci,
   output logic [W-1:0] s,
   output logic         co
);

   logic [W:0] wide;

   always_comb begin
      wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
      s    = wide[W-1:0];
      co   = wide[W];
   end

endmodule

// File: rtl/sadd_carry_map.sv
`timescale 1ns/1ps
module sadd_carry_map
   import simd_add_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic [LANES-1:0] lane_co,
   output logic [CO_W-1:0]  co_vec
);

   generate
      if (LANES == 4) begin : g_four
         assign co_vec = lane_co;
      end else if (LANES == 2) begin : g_two
         assign co_vec = {lane_co[1], 1'b0, lane_co[0], 1'b0};
      end else begin : g_one
         assign co_vec = {lane_co[0], 3'b000};
      end
   endgenerate

endmodule

// File: rtl/simd_add48.sv
`timescale 1ns/1ps
module simd_add48
   import simd_add_pkg::*;
#(
   parameter int HI_W  = 30,
   parameter int LO_W  = 18,
   parameter int LANES = 4
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [HI_W-1:0]        op_hi,
   input  logic [LO_W-1:0]        op_lo,
   input  logic [HI_W+LO_W-1:0]   op_c,
   input  logic [MODE_W-1:0]      mode,
   input  logic                   carry_in,
   output logic [HI_W+LO_W-1:0]   result,
   output logic [CO_W-1:0]        carry_out
);

   localparam int DW    = HI_W + LO_W;
   localparam int LW    = DW / LANES;
   localparam int SLOT0 = carry_slot(LANES, 0);

   // elaboration-time parameter checks
   generate
      if (!(LANES == 1 || LANES == 2 || LANES == 4)) begin : g_bad_lanes
         $error("simd_add48: LANES must be 1, 2 or 4");
      end
      if ((DW % LANES) != 0) begin : g_bad_split
         $error("simd_add48: total width must divide evenly into lanes");
      end
      if (HI_W < 1 || LO_W < 1) begin : g_bad_width
         $error("simd_add48: operand parts must be at least one bit");
      end
   endgenerate

   logic [DW-1:0]    opnd_eff;
   logic             is_sub;
   logic             is_valid;
   logic [DW-1:0]    sum_n;
   logic [LANES-1:0] lane_co;
   logic [CO_W-1:0]  co_n;

   sadd_decode #(
      .HI_W (HI_W),
      .LO_W (LO_W)
   ) u_dec (
      .part_hi  (op_hi),
      .part_lo  (op_lo),
      .mode     (mode),
      .opnd_eff (opnd_eff),
      .is_sub   (is_sub),
      .is_valid (is_valid)
   );

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         logic lane_ci;
         if (k == 0) begin : g_lo
            assign lane_ci = carry_in;
         end else begin : g_up
            assign lane_ci = is_sub;
         end
         sadd_lane #(.W(LW)) u_lane (
            .x  (op_c[k*LW +: LW]),
            .y  (opnd_eff[k*LW +: LW]),
            .ci (lane_ci),
            .s  (sum_n[k*LW +: LW]),
            .co (lane_co[k])
         );
      end
   endgenerate

   sadd_carry_map #(.LANES(LANES)) u_map (
      .lane_co (lane_co),
      .co_vec  (co_n)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         result    <= '0;
         carry_out <= '0;
      end else if (is_valid) begin
         result    <= sum_n;
         carry_out <= co_n;
      end
   end

   // ---------------- assertions ----------------
   logic [DW-1:0] joined_in;
   assign joined_in = {op_hi, op_lo};

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (result == '0) && (carry_out == '0));

   // R8
   hold_on_other_chk: assert property (@(posedge clk) disable iff (rst)
      !((mode == OP_ADD) || (mode == OP_SUB)) |=> $stable(result) && $stable(carry_out));

   // R1
   lane0_add_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == OP_ADD) |=>
         ({carry_out[SLOT0], result[LW-1:0]} ==
          ($past({1'b0, op_c[LW-1:0]}) + $past({1'b0, joined_in[LW-1:0]}) + $past(carry_in))));

   generate
      if (LANES > 1) begin : g_top_lane_chk
         // R4
         top_lane_sub_chk: assert property (@(posedge clk) disable iff (rst)
            (mode == OP_SUB) |=>
               (result[DW-1 -: LW] == ($past(op_c[DW-1 -: LW]) - $past(joined_in[DW-1 -: LW]))));
      end
      if (LANES == 2) begin : g_two_chk
         // R6
         spare_two_chk: assert property (@(posedge clk) disable iff (rst)
            (carry_out[0] == 1'b0) && (carry_out[2] == 1'b0));
      end
      if (LANES == 1) begin : g_one_chk
         // R7
         spare_one_chk: assert property (@(posedge clk) disable iff (rst)
            carry_out[2:0] == 3'b000);
      end
   endgenerate

endmodule

// File: tb/tb_simd_add48.sv
`timescale 1ns/1ps
module tb_simd_add48;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst;
   int   total = 0;
   int   bad   = 0;

   // full-size instance
   logic [29:0] hi;
   logic [17:0] lo;
   logic [47:0] c;
   logic [3:0]  mode;
   logic        cin;
   logic [47:0] res;
   logic [3:0]  co;

   simd_add48 dut (
      .clk(clk), .rst(rst), .op_hi(hi), .op_lo(lo), .op_c(c),
      .mode(mode), .carry_in(cin), .result(res), .carry_out(co)
   );

   // small instances, 8 bits wide
   logic [4:0] s_hi;
   logic [2:0] s_lo;
   logic [7:0] s_c;
   logic [3:0] s_mode;
   logic       s_cin;
   logic [7:0] r1, r2, r4;
   logic [3:0] c1, c2, c4;

   simd_add48 #(.HI_W(5), .LO_W(3), .LANES(1)) dut_s1 (
      .clk(clk), .rst(rst), .op_hi(s_hi), .op_lo(s_lo), .op_c(s_c),
      .mode(s_mode), .carry_in(s_cin), .result(r1), .carry_out(c1));
   simd_add48 #(.HI_W(5), .LO_W(3), .LANES(2)) dut_s2 (
      .clk(clk), .rst(rst), .op_hi(s_hi), .op_lo(s_lo), .op_c(s_c),
      .mode(s_mode), .carry_in(s_cin), .result(r2), .carry_out(c2));
   simd_add48 #(.HI_W(5), .LO_W(3), .LANES(4)) dut_s4 (
      .clk(clk), .rst(rst), .op_hi(s_hi), .op_lo(s_lo), .op_c(s_c),
      .mode(s_mode), .carry_in(s_cin), .result(r4), .carry_out(c4));

   // reference: returns {carry vector, result}
   function automatic logic [51:0] ref_op(input int dw, input int lanes,
                                          input logic [47:0] a, input logic [47:0] b,
                                          input logic ci, input logic sub);
      int          lw;
      int          slot;
      logic [63:0] m, av, bv, s, lc;
      logic [47:0] sum;
      logic [3:0]  cv;
      lw  = dw / lanes;
      sum = '0;
      cv  = '0;
      m   = (64'd1 << lw) - 64'd1;
      for (int k = 0; k < lanes; k++) begin
         av = ({16'b0, a} >> (k * lw)) & m;
         bv = ({16'b0, b} >> (k * lw)) & m;
         if (sub) av = (~av) & m;
         lc = (k == 0) ? {63'b0, ci} : {63'b0, sub};
         s  = av + bv + lc;
         sum = sum | 48'((s & m) << (k * lw));
         slot = (lanes == 4) ? k : ((lanes == 2) ? 2 * k + 1 : 3);
         cv[slot] = s[lw];
      end
      return {cv, sum};
   endfunction

   task automatic chk(input string req, input logic [51:0] act, input logic [51:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic big_op(input logic [47:0] a, input logic [47:0] b,
                         input logic ci, input logic [3:0] m);
      hi = a[47:18]; lo = a[17:0]; c = b; cin = ci; mode = m;
      @(negedge clk);
   endtask

   initial begin
      logic [51:0] e;
      logic [51:0] held;
      rst = 1'b1;
      hi = '0; lo = '0; c = '0; mode = 4'b0000; cin = 1'b0;
      s_hi = '0; s_lo = '0; s_c = '0; s_mode = 4'b0000; s_cin = 1'b0;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 reset big", {co, res}, 52'd0);
      chk("R9 reset small", {c4, r4}, 12'd0);
      rst = 1'b0;

      // R3: carry_in reaches only lane 0
      big_op(48'd0, 48'd0, 1'b1, 4'b0000);
      chk("R3 carry_in lowest lane", {co, res}, {4'b0000, 48'd1});
      // R2 R5: all-ones plus one wraps only lane 0
      big_op(48'hFFFF_FFFF_FFFF, 48'd1, 1'b0, 4'b0000);
      chk("R2 R5 lane wrap", {co, res}, {4'b0001, 48'hFFF_FFF_FFF_000});
      big_op(48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF, 1'b1, 4'b0000);
      chk("R2 R5 all carries", {co, res}, {4'b1111, 48'hFFE_FFE_FFE_FFF});
      // R4 subtract
      big_op(48'h1234_5678_9ABC, 48'h1234_5678_9ABC, 1'b1, 4'b0011);
      chk("R4 equal operands", {co, res}, {4'b1111, 48'd0});
      big_op(48'd1, 48'd0, 1'b1, 4'b0011);
      chk("R4 borrow stays in lane", {co, res}, {4'b1110, 48'h000_000_000_FFF});
      big_op(48'h0ABC_DEF0_1234, 48'h7777_8888_9999, 1'b0, 4'b0011);
      chk("R4 carry_in zero", {co, res},
          ref_op(48, 4, 48'h0ABC_DEF0_1234, 48'h7777_8888_9999, 1'b0, 1'b1));
      // R1 operand join
      big_op(48'hC000_0002_0001, 48'h0000_0000_0000, 1'b0, 4'b0000);
      chk("R1 join order", {co, res}, {4'b0000, 48'hC000_0002_0001});

      // R9 latency: no change before the clock edge
      big_op(48'd5, 48'd5, 1'b0, 4'b0000);
      hi = '0; lo = 18'd100; c = 48'd100; mode = 4'b0000;
      #1;
      chk("R9 no change before edge", {co, res}, {4'b0000, 48'd10});
      @(negedge clk);
      chk("R9 one cycle later", {co, res}, {4'b0000, 48'd200});

      // R8 hold for every other code
      for (int m = 0; m < 16; m++) begin
         if (m != 0 && m != 3) begin
            big_op(48'h0000_0300_0007, 48'h0000_0100_0009, 1'b0, 4'b0000);
            held = {co, res};
            big_op(48'hFFFF_0000_FFFF, 48'h1234_5678_9ABC, 1'b1, 4'(m));
            chk($sformatf("R8 hold mode %0d", m), {co, res}, held);
         end
      end

      // R9 reset in mid-operation
      big_op(48'd9, 48'd9, 1'b0, 4'b0000);
      rst = 1'b1;
      @(negedge clk);
      chk("R9 reset clears", {co, res}, 52'd0);
      rst = 1'b0;

      // sweep over the small instances
      for (int sub = 0; sub < 2; sub++) begin
         for (int ci = 0; ci < 2; ci++) begin
            for (int a = 0; a < 256; a++) begin
               for (int j = 0; j < 16; j++) begin
                  logic [7:0] bv;
                  bv = 8'(j * 17);
                  s_hi = a[7:3]; s_lo = a[2:0]; s_c = bv; s_cin = ci[0];
                  s_mode = sub[0] ? 4'b0011 : 4'b0000;
                  @(negedge clk);
                  e = ref_op(8, 1, 48'(a), 48'(bv), ci[0], sub[0]);
                  chk(sub[0] ? "R4 R7 one lane" : "R1 R7 one lane",
                      {40'd0, c1, r1}, {40'd0, e[51:48], e[7:0]});
                  e = ref_op(8, 2, 48'(a), 48'(bv), ci[0], sub[0]);
                  chk(sub[0] ? "R4 R6 two lanes" : "R1 R6 two lanes",
                      {40'd0, c2, r2}, {40'd0, e[51:48], e[7:0]});
                  e = ref_op(8, 4, 48'(a), 48'(bv), ci[0], sub[0]);
                  chk(sub[0] ? "R4 R5 four lanes" : "R1 R5 four lanes",
                      {40'd0, c4, r4}, {40'd0, e[51:48], e[7:0]});
               end
            end
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule